// File: doc/BRIEF.md
# SPI-Mode SD Command Sequencer

This block drives one SD/MMC command over a byte-wide SPI exchange port and collects the card's reply. The caller provides a 6-bit command index, a 32-bit argument, a reply-shape select and a flag that says whether a data block follows. The sequencer clocks out a fill byte and then the six-byte command frame. It then polls the card with 0xFF bytes until a reply byte arrives or the retry budget runs out. For the longer reply shapes it collects the extra bytes. It ends every operation with a one-cycle completion pulse. When a data block should follow and the reply was clean, it raises a hand-off strobe for a separate data engine.

A second request runs the card wake-up sequence. Chip select is held inactive while a fixed number of 0xFF bytes are exchanged, which gives the card its start-up clocks. Chip select is then asserted and stays asserted for later commands. No checksum is computed: only the reset command and the interface-condition command get their fixed checksum bytes.

Top module: `sd_spi_cmd_seq`

## Requirements
- R1: After reset, csActive, busy, done, dataGo, spiStart, timeoutErr and rspErr are all low.
- R2: An initReq in idle drives csActive low and exchanges exactly INIT_BYTES (default 10) bytes, all 0xFF. csActive goes high in the cycle that done pulses. The error flags are not changed.
- R3: A command exchanges 0xFF first. It then sends 0x40 OR the 6-bit opcode, and then the argument in four bytes, most significant first.
- R4: The seventh frame byte is 0x95 for opcode 0, 0x87 for opcode 8 and 0x00 for any other opcode.
- R5: After the frame, each polled byte sent is 0xFF. The first SKIP_COUNT (default 2) received poll bytes are discarded whatever their value. After that, the first received byte with bit 7 clear is taken as the R1 byte and becomes rspStatus[7:0], with rspStatus[15:8] zero.
- R6: If none of POLL_LIMIT (default 20000) polled bytes is accepted, timeoutErr is set and the operation ends with no further bytes. A byte accepted on the last permitted poll is not a timeout.
- R7: rspKind selects the extra bytes that follow the R1 byte. 2'b01 reads one byte into rspStatus[15:8]. 2'b10 reads four bytes into rspWord, first byte in bits 31:24. 2'b00 and 2'b11 read none.
- R8: rspErr is set when the collected 16-bit rspStatus is neither 0x0000 nor 0x0001. timeoutErr and rspErr are never both set.
- R9: done is high for exactly one cycle at the end of each operation. timeoutErr and rspErr hold their value until the next accepted cmdStart, which clears both.
- R10: dataGo pulses together with done only for a command that had cmdHasData high and ended with neither error.
- R11: initReq and cmdStart are ignored while busy. busy is high from the cycle after an accepted request through the done cycle.
- R12: spiStart is a one-cycle request. No new request is issued until spiReady has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Start the wake-up sequence (priority over cmdStart) |
| cmdStart | input | 1 | Start a command |
| cmdOpcode | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| rspKind | input | 2 | Reply shape select |
| cmdHasData | input | 1 | A data block follows this command |
| spiStart | output | 1 | Byte exchange request |
| spiTx | output | 8 | Byte to send, valid with spiStart |
| spiReady | input | 1 | Byte exchange finished |
| spiRx | input | 8 | Received byte, valid with spiReady |
| csActive | output | 1 | Card chip select asserted (active high) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| dataGo | output | 1 | Hand-off strobe to the data engine |
| timeoutErr | output | 1 | Sticky reply timeout |
| rspErr | output | 1 | Sticky reply error |
| rspStatus | output | 16 | R1 byte and optional second status byte |
| rspWord | output | 32 | Four-byte trailing reply |

## Verification
The bench feeds early reply bytes that already have bit 7 clear. A sequencer that skipped no bytes would accept them and finish the poll two bytes too soon. The bench puts the accepted byte on the very last permitted poll and also lets the budget run out. An off-by-one counter shows up there as a false timeout or as one extra poll byte. A second status byte of 0x04 behind a clean R1 byte must raise rspErr, which a design that checked only the R1 byte would miss. The bench also fires requests while the sequencer is busy, which must leave the byte stream and the busy flag untouched. And it runs idle cycles after an error, where a design that cleared its flags early would drop them.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_FRAME,
    ST_POLL,
    ST_EXTRA,
    ST_CHECK,
    ST_FIN
  } seq_state_e;

  localparam logic [1:0] KIND_SHORT   = 2'b00;
  localparam logic [1:0] KIND_STATUS2 = 2'b01;
  localparam logic [1:0] KIND_WORD4   = 2'b10;

  localparam int FRAME_BYTES = 7;

  typedef struct packed {
    logic latchCmd;
    logic startInit;
    logic clrCnt;
    logic incCnt;
    logic frameSel;
    logic capR1;
    logic capExtra;
    logic setTimeout;
    logic setRspErr;
  } dp_strobe_t;

endpackage

// File: rtl/sdcmd_datapath.sv
module sdcmd_datapath
  import sdcmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       st,
  input  logic [5:0]       cmdOpcode,
  input  logic [31:0]      cmdArg,
  input  logic [1:0]       rspKind,
  input  logic             cmdHasData,
  input  logic [7:0]       spiRx,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       txByte,
  output logic [2:0]       extraLen,
  output logic             respBad,
  output logic             wantData,
  output logic             timeoutErr,
  output logic             rspErr,
  output logic [15:0]      rspStatus,
  output logic [31:0]      rspWord
);

  logic [5:0]  opReg;
  logic [31:0] argReg;
  logic [1:0]  kindReg;
  logic [7:0]  checkByte;
  logic [7:0]  frameByte;

  // fixed checksums for the two commands that are checked before CRC is off
  always_comb begin
    if (opReg == 6'd0)      checkByte = 8'h95;
    else if (opReg == 6'd8) checkByte = 8'h87;
    else                    checkByte = 8'h00;
  end

  always_comb begin
    case (cnt[2:0])
      3'd1:    frameByte = {2'b01, opReg};
      3'd2:    frameByte = argReg[31:24];
      3'd3:    frameByte = argReg[23:16];
      3'd4:    frameByte = argReg[15:8];
      3'd5:    frameByte = argReg[7:0];
      3'd6:    frameByte = checkByte;
      default: frameByte = 8'hFF;
    endcase
  end

  assign txByte = st.frameSel ? frameByte : 8'hFF;

  always_comb begin
    case (kindReg)
      KIND_STATUS2: extraLen = 3'd1;
      KIND_WORD4:   extraLen = 3'd4;
      default:      extraLen = 3'd0;
    endcase
  end

  assign respBad = (rspStatus > 16'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg      <= '0;
      argReg     <= '0;
      kindReg    <= KIND_SHORT;
      wantData   <= 1'b0;
      cnt        <= '0;
      rspStatus  <= '0;
      rspWord    <= '0;
      timeoutErr <= 1'b0;
      rspErr     <= 1'b0;
    end else begin
      if (st.latchCmd) begin
        opReg      <= cmdOpcode;
        argReg     <= cmdArg;
        kindReg    <= rspKind;
        wantData   <= cmdHasData;
        rspStatus  <= '0;
        rspWord    <= '0;
        timeoutErr <= 1'b0;
        rspErr     <= 1'b0;
      end
      if (st.startInit) wantData <= 1'b0;
      if (st.clrCnt)      cnt <= '0;
      else if (st.incCnt) cnt <= cnt + 1'b1;
      if (st.capR1) rspStatus <= {8'h00, spiRx};
      if (st.capExtra) begin
        if (kindReg == KIND_STATUS2) rspStatus[15:8] <= spiRx;
        else                         rspWord <= {rspWord[23:0], spiRx};
      end
      if (st.setTimeout) timeoutErr <= 1'b1;
      if (st.setRspErr)  rspErr     <= 1'b1;
    end
  end

endmodule

// File: rtl/sdcmd_control.sv
module sdcmd_control
  import sdcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 20000,
  parameter int SKIP_COUNT = 2,
  parameter int INIT_BYTES = 10,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initReq,
  input  logic             cmdStart,
  input  logic             spiReady,
  input  logic             rxMsb,
  input  logic [CNT_W-1:0] cnt,
  input  logic [2:0]       extraLen,
  input  logic             respBad,
  output dp_strobe_t       st,
  output logic             spiStart,
  output logic             csActive,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_BYTES - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_LIMIT - 1);
  localparam logic [CNT_W-1:0] SKIP_MIN   = CNT_W'(SKIP_COUNT);

  seq_state_e state, nextState;
  logic pending;
  logic csReg;
  logic xferPhase;
  logic byteDone;
  logic rxOk;
  logic initLast;

  assign xferPhase = (state == ST_INIT) || (state == ST_FRAME) ||
                     (state == ST_POLL) || (state == ST_EXTRA);
  assign spiStart  = xferPhase && !pending;
  assign byteDone  = xferPhase && pending && spiReady;
  assign rxOk      = !rxMsb && (cnt >= SKIP_MIN);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign csActive  = csReg;

  always_comb begin
    st        = '0;
    nextState = state;
    initLast  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (initReq) begin
          st.startInit = 1'b1;
          st.clrCnt    = 1'b1;
          nextState    = ST_INIT;
        end else if (cmdStart) begin
          st.latchCmd = 1'b1;
          st.clrCnt   = 1'b1;
          nextState   = ST_FRAME;
        end
      end
      ST_INIT: begin
        if (byteDone) begin
          if (cnt == INIT_LAST) begin
            initLast  = 1'b1;
            nextState = ST_FIN;
          end else begin
            st.incCnt = 1'b1;
          end
        end
      end
      ST_FRAME: begin
        st.frameSel = 1'b1;
        if (byteDone) begin
          if (cnt == FRAME_LAST) begin
            st.clrCnt = 1'b1;
            nextState = ST_POLL;
          end else begin
            st.incCnt = 1'b1;
          end
        end
      end
      ST_POLL: begin
        if (byteDone) begin
          if (rxOk) begin
            st.capR1  = 1'b1;
            st.clrCnt = 1'b1;
            nextState = (extraLen == 3'd0) ? ST_CHECK : ST_EXTRA;
          end else if (cnt == POLL_LAST) begin
            st.setTimeout = 1'b1;
            nextState     = ST_FIN;
          end else begin
            st.incCnt = 1'b1;
          end
        end
      end
      ST_EXTRA: begin
        if (byteDone) begin
          st.capExtra = 1'b1;
          if (cnt == CNT_W'(extraLen) - CNT_W'(1)) nextState = ST_CHECK;
          else                                      st.incCnt = 1'b1;
        end
      end
      ST_CHECK: begin
        st.setRspErr = respBad;
        nextState    = ST_FIN;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      csReg   <= 1'b0;
    end else begin
      state <= nextState;
      if (spiStart)      pending <= 1'b1;
      else if (byteDone) pending <= 1'b0;
      if (st.startInit)  csReg <= 1'b0;
      else if (initLast) csReg <= 1'b1;
    end
  end

endmodule

// File: rtl/sd_spi_cmd_seq.sv
module sd_spi_cmd_seq
  import sdcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 20000,
  parameter int SKIP_COUNT = 2,
  parameter int INIT_BYTES = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        initReq,
  input  logic        cmdStart,
  input  logic [5:0]  cmdOpcode,
  input  logic [31:0] cmdArg,
  input  logic [1:0]  rspKind,
  input  logic        cmdHasData,
  output logic        spiStart,
  output logic [7:0]  spiTx,
  input  logic        spiReady,
  input  logic [7:0]  spiRx,
  output logic        csActive,
  output logic        busy,
  output logic        done,
  output logic        dataGo,
  output logic        timeoutErr,
  output logic        rspErr,
  output logic [15:0] rspStatus,
  output logic [31:0] rspWord
);

  localparam int CNT_W = $clog2(POLL_LIMIT + INIT_BYTES + FRAME_BYTES + 1);

  dp_strobe_t       strobes;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       extraLen;
  logic             respBad;
  logic             wantData;

  sdcmd_control #(
    .POLL_LIMIT(POLL_LIMIT),
    .SKIP_COUNT(SKIP_COUNT),
    .INIT_BYTES(INIT_BYTES),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .initReq  (initReq),
    .cmdStart (cmdStart),
    .spiReady (spiReady),
    .rxMsb    (spiRx[7]),
    .cnt      (cnt),
    .extraLen (extraLen),
    .respBad  (respBad),
    .st       (strobes),
    .spiStart (spiStart),
    .csActive (csActive),
    .busy     (busy),
    .done     (done)
  );

  sdcmd_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobes),
    .cmdOpcode  (cmdOpcode),
    .cmdArg     (cmdArg),
    .rspKind    (rspKind),
    .cmdHasData (cmdHasData),
    .spiRx      (spiRx),
    .cnt        (cnt),
    .txByte     (spiTx),
    .extraLen   (extraLen),
    .respBad    (respBad),
    .wantData   (wantData),
    .timeoutErr (timeoutErr),
    .rspErr     (rspErr),
    .rspStatus  (rspStatus),
    .rspWord    (rspWord)
  );

  assign dataGo = done && wantData && !timeoutErr && !rspErr;

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker (
  input logic clk,
  input logic rstN,
  input logic initReq,
  input logic cmdStart,
  input logic spiStart,
  input logic busy,
  input logic done,
  input logic dataGo,
  input logic csActive,
  input logic timeoutErr,
  input logic rspErr
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |=> !spiStart); // R12
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |-> busy); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_TIMEOUT_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> done); // R6
  AST_RSPERR_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspErr) |-> done); // R8
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(timeoutErr && rspErr)); // R8
  AST_RSPERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rspErr) |-> ($past(cmdStart) && !$past(busy))); // R9
  AST_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutErr) |-> ($past(cmdStart) && !$past(busy))); // R9
  AST_GO_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    dataGo |-> (done && !timeoutErr && !rspErr)); // R10
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(initReq || cmdStart)); // R11
  AST_CS_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csActive) |-> busy); // R2

endmodule

bind sd_spi_cmd_seq sdcmd_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .initReq    (initReq),
  .cmdStart   (cmdStart),
  .spiStart   (spiStart),
  .busy       (busy),
  .done       (done),
  .dataGo     (dataGo),
  .csActive   (csActive),
  .timeoutErr (timeoutErr),
  .rspErr     (rspErr)
);

// File: tb/tb_sd_spi_cmd_seq.sv
module tb_sd_spi_cmd_seq;

  localparam int TB_POLL = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initReq = 1'b0;
  logic        cmdStart = 1'b0;
  logic [5:0]  cmdOpcode = '0;
  logic [31:0] cmdArg = '0;
  logic [1:0]  rspKind = '0;
  logic        cmdHasData = 1'b0;
  logic        spiStart;
  logic [7:0]  spiTx;
  logic        spiReady = 1'b0;
  logic [7:0]  spiRx = 8'hFF;
  logic        csActive, busy, done, dataGo, timeoutErr, rspErr;
  logic [15:0] rspStatus;
  logic [31:0] rspWord;

  sd_spi_cmd_seq #(.POLL_LIMIT(TB_POLL)) dut (
    .clk(clk), .rstN(rstN), .initReq(initReq), .cmdStart(cmdStart),
    .cmdOpcode(cmdOpcode), .cmdArg(cmdArg), .rspKind(rspKind),
    .cmdHasData(cmdHasData), .spiStart(spiStart), .spiTx(spiTx),
    .spiReady(spiReady), .spiRx(spiRx), .csActive(csActive), .busy(busy),
    .done(done), .dataGo(dataGo), .timeoutErr(timeoutErr), .rspErr(rspErr),
    .rspStatus(rspStatus), .rspWord(rspWord)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [7:0] txLog[$];
  logic [7:0] rxQ[$];
  int frameLeft = 0;

  // cycle model state
  bit modelBusy = 0, modelCs = 0, modelTo = 0, modelRe = 0;
  bit accPend = 0, accCmd = 0, doneLast = 0;
  bit pendTo = 0, pendRe = 0, pendInit = 0;
  bit sawDone, sawGo;
  logic [15:0] gotStatus;
  logic [31:0] gotWord;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // SPI byte responder
  initial begin
    forever begin
      if (spiStart === 1'b1) begin
        txLog.push_back(spiTx);
        for (int w = 0; w <= int'(txLog.size() % 3); w++) begin
          @(negedge clk);
          chk("R12", "start while outstanding", {31'd0, spiStart}, 32'd0);
        end
        if (frameLeft > 0) begin
          spiRx = 8'hFF;
          frameLeft--;
        end else if (rxQ.size() > 0) spiRx = rxQ.pop_front();
        else spiRx = 8'hFF;
        spiReady = 1'b1;
        @(negedge clk);
        spiReady = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // one cycle, with the model compared on every clock
  task automatic tick();
    @(negedge clk);
    if (accPend) begin
      modelBusy = 1;
      if (accCmd) begin modelTo = 0; modelRe = 0; end
      else modelCs = 0;
      accPend = 0;
    end
    if (doneLast) begin
      chk("R9", "done width", {31'd0, done}, 32'd0);
      modelBusy = 0;
      doneLast = 0;
    end else if (done === 1'b1) begin
      doneLast = 1;
      sawDone = 1;
      sawGo = dataGo;
      gotStatus = rspStatus;
      gotWord = rspWord;
      modelTo = pendTo;
      modelRe = pendRe;
      if (pendInit) modelCs = 1;
    end
    chk("R11", "busy", {31'd0, busy}, {31'd0, modelBusy});
    chk("R2", "csActive", {31'd0, csActive}, {31'd0, modelCs});
    chk("R6", "timeoutErr", {31'd0, timeoutErr}, {31'd0, modelTo});
    chk("R9", "rspErr", {31'd0, rspErr}, {31'd0, modelRe});
  endtask

  task automatic waitDone();
    sawDone = 0;
    for (int g = 0; g < 3000 && !sawDone; g++) tick();
    chk("R9", "operation completed", {31'd0, sawDone}, 32'd1);
    tick();
  endtask

  task automatic runInit();
    txLog.delete();
    rxQ.delete();
    frameLeft = 0;
    pendInit = 1; pendTo = modelTo; pendRe = modelRe;
    initReq = 1'b1; accPend = 1; accCmd = 0;
    tick();
    initReq = 1'b0;
    waitDone();
    chk("R2", "init byte count", txLog.size(), 10);
    foreach (txLog[i]) chk("R2", "init byte", {24'd0, txLog[i]}, 32'hFF);
    chk("R10", "no dataGo on init", {31'd0, sawGo}, 32'd0);
  endtask

  task automatic runCmd(input string tag, input logic [5:0] op, input logic [31:0] arg,
                        input logic [1:0] kind, input bit hasData,
                        input bit expTo, input bit expRe, input bit expGo,
                        input logic [15:0] expStatus, input logic [31:0] expWord,
                        input int expBytes, input logic [7:0] expCrc);
    txLog.delete();
    frameLeft = 7;
    pendInit = 0; pendTo = expTo; pendRe = expRe;
    cmdOpcode = op; cmdArg = arg; rspKind = kind; cmdHasData = hasData;
    cmdStart = 1'b1; accPend = 1; accCmd = 1;
    tick();
    cmdStart = 1'b0;
    waitDone();
    chk(tag, "byte count", txLog.size(), expBytes);
    if (txLog.size() >= 7) begin
      chk("R3", "fill byte", {24'd0, txLog[0]}, 32'hFF);
      chk("R3", "opcode byte", {24'd0, txLog[1]}, {24'd0, 2'b01, op});
      chk("R3", "arg byte 3", {24'd0, txLog[2]}, {24'd0, arg[31:24]});
      chk("R3", "arg byte 2", {24'd0, txLog[3]}, {24'd0, arg[23:16]});
      chk("R3", "arg byte 1", {24'd0, txLog[4]}, {24'd0, arg[15:8]});
      chk("R3", "arg byte 0", {24'd0, txLog[5]}, {24'd0, arg[7:0]});
      chk("R4", "checksum", {24'd0, txLog[6]}, {24'd0, expCrc});
      for (int i = 7; i < txLog.size(); i++)
        chk("R5", "poll byte", {24'd0, txLog[i]}, 32'hFF);
    end
    chk("R10", "dataGo", {31'd0, sawGo}, {31'd0, expGo});
    if (!expTo) begin
      chk("R7", "rspStatus", {16'd0, gotStatus}, {16'd0, expStatus});
      chk("R7", "rspWord", gotWord, expWord);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "csActive in reset", {31'd0, csActive}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "dataGo", {31'd0, dataGo}, 32'd0);
    chk("R1", "spiStart", {31'd0, spiStart}, 32'd0);
    chk("R1", "errors", {30'd0, timeoutErr, rspErr}, 32'd0);
    chk("R1", "csActive", {31'd0, csActive}, 32'd0);
    tick();

    runInit();

    // R5: early bytes with bit 7 clear are still discarded
    rxQ = '{8'h01, 8'h00, 8'h01};
    runCmd("R5", 6'd0, 32'h0, 2'b00, 1'b0, 0, 0, 0, 16'h0001, 32'h0, 10, 8'h95);
    // R5: bit-7-set byte after the skip window is rejected
    rxQ = '{8'hFF, 8'hFF, 8'hFF, 8'h80, 8'h00};
    runCmd("R5", 6'd8, 32'h000001AA, 2'b00, 1'b0, 0, 0, 0, 16'h0000, 32'h0, 12, 8'h87);
    // R10: data hand-off on clean reply
    rxQ = '{8'hFF, 8'hFF, 8'h00};
    runCmd("R10", 6'd17, 32'h12345678, 2'b00, 1'b1, 0, 0, 1, 16'h0000, 32'h0, 10, 8'h00);
    // R8: bad R1, no hand-off
    rxQ = '{8'hFF, 8'hFF, 8'h05};
    runCmd("R8", 6'd17, 32'hA0B0C0D0, 2'b00, 1'b1, 0, 1, 0, 16'h0005, 32'h0, 10, 8'h00);
    // R9: error stays through idle cycles (model compares each cycle)
    repeat (5) tick();
    // R7: two-byte status, clean; start clears rspErr
    rxQ = '{8'hFF, 8'hFF, 8'h00, 8'h00};
    runCmd("R7", 6'd13, 32'h0, 2'b01, 1'b0, 0, 0, 0, 16'h0000, 32'h0, 11, 8'h00);
    // R8: clean R1 but non-zero second status byte
    rxQ = '{8'hFF, 8'hFF, 8'h00, 8'h04};
    runCmd("R8", 6'd13, 32'h0, 2'b01, 1'b1, 0, 1, 0, 16'h0400, 32'h0, 11, 8'h00);
    // R7: four-byte word
    rxQ = '{8'hFF, 8'hFF, 8'h01, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
    runCmd("R7", 6'd58, 32'h0, 2'b10, 1'b0, 0, 0, 0, 16'h0001, 32'hAABBCCDD, 14, 8'h00);
    // R7: code 2'b11 reads no extra bytes
    rxQ = '{8'hFF, 8'hFF, 8'h00, 8'h77};
    runCmd("R7", 6'd55, 32'h0, 2'b11, 1'b0, 0, 0, 0, 16'h0000, 32'h0, 10, 8'h00);
    rxQ.delete();
    // R6: budget exhausted
    runCmd("R6", 6'd9, 32'h0, 2'b00, 1'b1, 1, 0, 0, 16'h0, 32'h0, 7 + TB_POLL, 8'h00);
    repeat (3) tick();
    // R6: accepted on last permitted poll
    rxQ.delete();
    for (int i = 0; i < TB_POLL - 1; i++) rxQ.push_back(8'hFF);
    rxQ.push_back(8'h00);
    runCmd("R6", 6'd9, 32'h0, 2'b00, 1'b0, 0, 0, 0, 16'h0, 32'h0, 7 + TB_POLL, 8'h00);

    // R11: requests while busy are ignored
    txLog.delete();
    rxQ = '{8'hFF, 8'hFF, 8'h00};
    frameLeft = 7;
    pendInit = 0; pendTo = 0; pendRe = 0;
    cmdOpcode = 6'd2; cmdArg = 32'h0; rspKind = 2'b00; cmdHasData = 1'b0;
    cmdStart = 1'b1; accPend = 1; accCmd = 1;
    tick();
    cmdStart = 1'b0;
    repeat (4) tick();
    cmdOpcode = 6'd5; cmdStart = 1'b1; initReq = 1'b1;
    tick();
    cmdStart = 1'b0; initReq = 1'b0;
    waitDone();
    repeat (6) tick();
    chk("R11", "byte count", txLog.size(), 10);
    chk("R11", "opcode byte", {24'd0, txLog[1]}, 32'h42);

    // R2: second wake-up keeps error flags and toggles chip select
    rxQ = '{8'hFF, 8'hFF, 8'h09};
    runCmd("R8", 6'd1, 32'h0, 2'b00, 1'b0, 0, 1, 0, 16'h0009, 32'h0, 10, 8'h00);
    runInit();
    repeat (3) tick();
    finishRun();
  end

endmodule